// File: doc/BRIEF.md
# Bidirectional Slotted Ring Stop

This block is one node of a slotted on-chip ring. Every agent on the chip (a core, a cache slice, a graphics or media unit, the system agent) owns one such stop. The ring is made of four independent message classes: data, request, acknowledge and snoop. Each class has one lane turning clockwise and one turning counter-clockwise. A slot on any lane moves exactly one stop per clock.

For every class the stop does three things. It takes out slots addressed to its own agent and hands them to a valid/ready delivery port. It passes all other slots on unchanged. It puts local messages from a valid/ready injection port onto the ring.

No central arbiter exists. The upstream neighbour tells the stop, one clock ahead, whether the slot arriving next on a lane is empty. The stop injects only into a slot announced that way. Each message goes in the direction with fewer hops to its destination. The stop in turn produces the same one-clock-early empty indication for its downstream neighbour.

Top module: `ring_stop`

## Requirements
- R1: In the first cycle after synchronous reset, every lane output is empty, no delivery is offered, and no injection port is ready.
- R2: A valid incoming slot whose destination differs from the stop's ID leaves on the same lane one clock later, with destination and payload unchanged. In the cycle it arrives, the lane's early-empty output is low. Lane index is 2*class + direction, with direction 0 = clockwise and 1 = counter-clockwise. Classes are 0 data, 1 request, 2 acknowledge, 3 snoop.
- R3: A valid incoming slot addressed to the stop is offered on that class's delivery port in the cycle it arrives. If the port is ready, the slot leaves one clock later marked empty, and the lane's early-empty output is high in the arrival cycle.
- R4: If the delivery port is not ready, a slot addressed to the stop stays on the ring: it leaves one clock later, still valid, with the same destination and payload.
- R5: If addressed slots arrive on both lanes of one class in the same cycle, the clockwise one is delivered and the counter-clockwise one continues on its lane.
- R6: An injected message goes clockwise when (dst - id) mod N <= (id - dst) mod N, and counter-clockwise otherwise. Ties, including dst equal to the stop's own ID, go clockwise.
- R7: The injection port of a class is ready only when the previous cycle flagged as empty the incoming slot on the chosen lane. An accepted message appears on that lane's output one clock later. While not ready, nothing is injected.
- R8: A slot in transit that was not announced empty always passes through, even while a local message for that lane is pending.
- R9: The classes are independent: activity in one class changes only that class's two lane outputs and its delivery port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 2*NUM_CLASSES | Incoming slot occupied, per lane |
| in_dst | input | 2*NUM_CLASSES*ID_W | Incoming slot destination ID, per lane |
| in_data | input | 2*NUM_CLASSES*DATA_W | Incoming slot payload, per lane |
| in_empty_next | input | 2*NUM_CLASSES | Upstream says the next slot on this lane is empty |
| out_valid | output | 2*NUM_CLASSES | Outgoing slot occupied, per lane |
| out_dst | output | 2*NUM_CLASSES*ID_W | Outgoing slot destination, per lane |
| out_data | output | 2*NUM_CLASSES*DATA_W | Outgoing slot payload, per lane |
| out_empty_next | output | 2*NUM_CLASSES | Tells downstream the slot leaving next clock is empty |
| inj_valid | input | NUM_CLASSES | Local message present, per class |
| inj_ready | output | NUM_CLASSES | Local message accepted this cycle |
| inj_dst | input | NUM_CLASSES*ID_W | Local message destination |
| inj_data | input | NUM_CLASSES*DATA_W | Local message payload |
| dlv_valid | output | NUM_CLASSES | Slot for this agent offered |
| dlv_ready | input | NUM_CLASSES | Agent takes the offered slot |
| dlv_data | output | NUM_CLASSES*DATA_W | Delivered payload |

## Verification
The bench builds a ring of six stops, sits at stop 2 and uses a 16-bit payload. With six stops, a sweep over every destination covers every hop count in both directions. It also reaches the exact tie at distance three and the self-addressed tie. That sweep runs across all four classes, so each one is also checked for independence from the others. Directed cycles cover pass-through, delivery with and without ready, the two-lane collision, and injection held off by unannounced slots.

// File: rtl/ring_pkg.sv
package ring_pkg;

    localparam int NUM_CLASSES = 4;

    typedef enum logic [1:0] {
        CLS_DATA  = 2'd0,
        CLS_REQ   = 2'd1,
        CLS_ACK   = 2'd2,
        CLS_SNOOP = 2'd3
    } ring_class_e;

    typedef enum logic {
        DIR_CW  = 1'b0,
        DIR_CCW = 1'b1
    } ring_dir_e;

    // Counter-clockwise only when strictly shorter; ties stay clockwise.
    function automatic ring_dir_e pick_dir(input int n, input int here, input int dst);
        int cw_hops;
        int ccw_hops;
        cw_hops  = (dst - here + n) % n;
        ccw_hops = (here - dst + n) % n;
        return (ccw_hops < cw_hops) ? DIR_CCW : DIR_CW;
    endfunction

endpackage

// File: rtl/ring_dir_sel.sv
module ring_dir_sel #(
    parameter int NUM_STOPS = 8,
    parameter int STOP_ID   = 0,
    parameter int ID_W      = 3
) (
    input  logic [ID_W-1:0] dst,
    output ring_pkg::ring_dir_e dir
);
    always_comb begin
        dir = ring_pkg::pick_dir(NUM_STOPS, STOP_ID, int'(dst));
    end
endmodule

// File: rtl/ring_link.sv
module ring_link #(
    parameter int STOP_ID = 0,
    parameter int ID_W    = 3,
    parameter int DATA_W  = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ID_W-1:0]   in_dst,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_empty_next,
    input  logic              inj_go,
    input  logic [ID_W-1:0]   inj_dst,
    input  logic [DATA_W-1:0] inj_data,
    input  logic              take,
    output logic              hit,
    output logic              free,
    output logic              out_valid,
    output logic [ID_W-1:0]   out_dst,
    output logic [DATA_W-1:0] out_data,
    output logic              out_empty_next
);
    typedef struct packed {
        logic              v;
        logic [ID_W-1:0]   dst;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t cur, nxt, slot_q;
    logic  free_q;

    assign cur  = '{v: in_valid, dst: in_dst, data: in_data};
    assign hit  = in_valid && (in_dst == ID_W'(STOP_ID));
    assign free = free_q;

    always_comb begin
        nxt = cur;
        if (inj_go) begin
            nxt = '{v: 1'b1, dst: inj_dst, data: inj_data};
        end else if (take) begin
            nxt.v = 1'b0;
        end
    end

    assign out_empty_next = !nxt.v;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            free_q <= 1'b0;
        end else begin
            slot_q <= nxt;
            free_q <= in_empty_next;
        end
    end

    assign out_valid = slot_q.v;
    assign out_dst   = slot_q.dst;
    assign out_data  = slot_q.data;
endmodule

// File: rtl/ring_lane.sv
module ring_lane #(
    parameter int NUM_STOPS = 8,
    parameter int STOP_ID   = 0,
    parameter int ID_W      = 3,
    parameter int DATA_W    = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          in_valid,
    input  logic [2*ID_W-1:0]   in_dst,
    input  logic [2*DATA_W-1:0] in_data,
    input  logic [1:0]          in_empty_next,
    output logic [1:0]          out_valid,
    output logic [2*ID_W-1:0]   out_dst,
    output logic [2*DATA_W-1:0] out_data,
    output logic [1:0]          out_empty_next,
    input  logic                inj_valid,
    output logic                inj_ready,
    input  logic [ID_W-1:0]     inj_dst,
    input  logic [DATA_W-1:0]   inj_data,
    output logic                dlv_valid,
    input  logic                dlv_ready,
    output logic [DATA_W-1:0]   dlv_data
);
    import ring_pkg::*;

    ring_dir_e  dir;
    logic [1:0] hit, free, take, go;

    ring_dir_sel #(
        .NUM_STOPS(NUM_STOPS),
        .STOP_ID  (STOP_ID),
        .ID_W     (ID_W)
    ) u_dir (
        .dst(inj_dst),
        .dir(dir)
    );

    // Clockwise lane wins the single delivery port.
    assign take[0]   = hit[0] && dlv_ready;
    assign take[1]   = hit[1] && !hit[0] && dlv_ready;
    assign dlv_valid = |hit;
    assign dlv_data  = hit[0] ? in_data[0 +: DATA_W] : in_data[DATA_W +: DATA_W];

    assign inj_ready = free[dir];
    assign go[0]     = inj_valid && inj_ready && (dir == DIR_CW);
    assign go[1]     = inj_valid && inj_ready && (dir == DIR_CCW);

    for (genvar d = 0; d < 2; d++) begin : g_dir
        ring_link #(
            .STOP_ID(STOP_ID),
            .ID_W   (ID_W),
            .DATA_W (DATA_W)
        ) u_link (
            .clk           (clk),
            .rst           (rst),
            .in_valid      (in_valid[d]),
            .in_dst        (in_dst[d*ID_W +: ID_W]),
            .in_data       (in_data[d*DATA_W +: DATA_W]),
            .in_empty_next (in_empty_next[d]),
            .inj_go        (go[d]),
            .inj_dst       (inj_dst),
            .inj_data      (inj_data),
            .take          (take[d]),
            .hit           (hit[d]),
            .free          (free[d]),
            .out_valid     (out_valid[d]),
            .out_dst       (out_dst[d*ID_W +: ID_W]),
            .out_data      (out_data[d*DATA_W +: DATA_W]),
            .out_empty_next(out_empty_next[d])
        );
    end
endmodule

// File: rtl/ring_stop.sv
module ring_stop #(
    parameter int NUM_STOPS = 8,
    parameter int STOP_ID   = 0,
    parameter int DATA_W    = 256,
    localparam int NC       = ring_pkg::NUM_CLASSES,
    localparam int ID_W     = $clog2(NUM_STOPS),
    localparam int LANES    = 2 * NC
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LANES-1:0]       in_valid,
    input  logic [LANES*ID_W-1:0]  in_dst,
    input  logic [LANES*DATA_W-1:0] in_data,
    input  logic [LANES-1:0]       in_empty_next,
    output logic [LANES-1:0]       out_valid,
    output logic [LANES*ID_W-1:0]  out_dst,
    output logic [LANES*DATA_W-1:0] out_data,
    output logic [LANES-1:0]       out_empty_next,
    input  logic [NC-1:0]          inj_valid,
    output logic [NC-1:0]          inj_ready,
    input  logic [NC*ID_W-1:0]     inj_dst,
    input  logic [NC*DATA_W-1:0]   inj_data,
    output logic [NC-1:0]          dlv_valid,
    input  logic [NC-1:0]          dlv_ready,
    output logic [NC*DATA_W-1:0]   dlv_data
);
    for (genvar c = 0; c < NC; c++) begin : g_cls
        ring_lane #(
            .NUM_STOPS(NUM_STOPS),
            .STOP_ID  (STOP_ID),
            .ID_W     (ID_W),
            .DATA_W   (DATA_W)
        ) u_lane (
            .clk           (clk),
            .rst           (rst),
            .in_valid      (in_valid[2*c +: 2]),
            .in_dst        (in_dst[2*c*ID_W +: 2*ID_W]),
            .in_data       (in_data[2*c*DATA_W +: 2*DATA_W]),
            .in_empty_next (in_empty_next[2*c +: 2]),
            .out_valid     (out_valid[2*c +: 2]),
            .out_dst       (out_dst[2*c*ID_W +: 2*ID_W]),
            .out_data      (out_data[2*c*DATA_W +: 2*DATA_W]),
            .out_empty_next(out_empty_next[2*c +: 2]),
            .inj_valid     (inj_valid[c]),
            .inj_ready     (inj_ready[c]),
            .inj_dst       (inj_dst[c*ID_W +: ID_W]),
            .inj_data      (inj_data[c*DATA_W +: DATA_W]),
            .dlv_valid     (dlv_valid[c]),
            .dlv_ready     (dlv_ready[c]),
            .dlv_data      (dlv_data[c*DATA_W +: DATA_W])
        );
    end
endmodule

// File: rtl/ring_stop_chk.sv
module ring_stop_chk #(
    parameter int NUM_STOPS = 8,
    parameter int STOP_ID   = 0,
    parameter int DATA_W    = 256,
    localparam int NC       = ring_pkg::NUM_CLASSES,
    localparam int ID_W     = $clog2(NUM_STOPS),
    localparam int LANES    = 2 * NC
) (
    input logic                    clk,
    input logic                    rst,
    input logic [LANES-1:0]        in_valid,
    input logic [LANES*ID_W-1:0]   in_dst,
    input logic [LANES*DATA_W-1:0] in_data,
    input logic [LANES-1:0]        in_empty_next,
    input logic [LANES-1:0]        out_valid,
    input logic [LANES*ID_W-1:0]   out_dst,
    input logic [LANES*DATA_W-1:0] out_data,
    input logic [LANES-1:0]        out_empty_next,
    input logic [NC-1:0]           inj_valid,
    input logic [NC-1:0]           inj_ready,
    input logic [NC*ID_W-1:0]      inj_dst,
    input logic [NC*DATA_W-1:0]    inj_data,
    input logic [NC-1:0]           dlv_valid,
    input logic [NC-1:0]           dlv_ready,
    input logic [NC*DATA_W-1:0]    dlv_data
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        p_pass_r2: assert property (@(posedge clk) disable iff (rst)
            (in_valid[k] && in_dst[k*ID_W +: ID_W] != ID_W'(STOP_ID))
            |=> (out_valid[k] && out_dst[k*ID_W +: ID_W] == $past(in_dst[k*ID_W +: ID_W])));
    end

    for (genvar c = 0; c < NC; c++) begin : g_cls
        p_hold_r4: assert property (@(posedge clk) disable iff (rst)
            (in_valid[2*c] && in_dst[2*c*ID_W +: ID_W] == ID_W'(STOP_ID) && !dlv_ready[c])
            |=> out_valid[2*c]);

        p_cw_first_r5: assert property (@(posedge clk) disable iff (rst)
            (in_valid[2*c] && in_valid[2*c+1] && dlv_ready[c]
             && in_dst[2*c*ID_W +: ID_W] == ID_W'(STOP_ID)
             && in_dst[(2*c+1)*ID_W +: ID_W] == ID_W'(STOP_ID))
            |=> (!out_valid[2*c] && out_valid[2*c+1]));

        p_ready_hint_r7: assert property (@(posedge clk) disable iff (rst)
            inj_ready[c] |-> $past(in_empty_next[2*c] || in_empty_next[2*c+1]));

        p_inject_lands_r7: assert property (@(posedge clk) disable iff (rst)
            (inj_valid[c] && inj_ready[c]) |=> (out_valid[2*c] || out_valid[2*c+1]));
    end
endmodule

bind ring_stop ring_stop_chk #(
    .NUM_STOPS(NUM_STOPS),
    .STOP_ID  (STOP_ID),
    .DATA_W   (DATA_W)
) u_chk (.*);

// File: tb/ring_stop_test.sv
module ring_stop_test;
    localparam int CLK_PERIOD = 10;
    localparam int N      = 6;
    localparam int ME     = 2;
    localparam int DW     = 16;
    localparam int NC     = 4;
    localparam int IW     = $clog2(N);
    localparam int LANES  = 2 * NC;

    logic clk = 1'b0;
    logic rst;
    logic [LANES-1:0]    in_valid, in_empty_next, out_valid, out_empty_next;
    logic [LANES*IW-1:0] in_dst, out_dst;
    logic [LANES*DW-1:0] in_data, out_data;
    logic [NC-1:0]       inj_valid, inj_ready, dlv_valid, dlv_ready;
    logic [NC*IW-1:0]    inj_dst;
    logic [NC*DW-1:0]    inj_data, dlv_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = !clk;

    ring_stop #(.NUM_STOPS(N), .STOP_ID(ME), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_dst(in_dst), .in_data(in_data),
        .in_empty_next(in_empty_next),
        .out_valid(out_valid), .out_dst(out_dst), .out_data(out_data),
        .out_empty_next(out_empty_next),
        .inj_valid(inj_valid), .inj_ready(inj_ready),
        .inj_dst(inj_dst), .inj_data(inj_data),
        .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_data(dlv_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_inputs();
        in_valid = '0; in_dst = '0; in_data = '0; in_empty_next = '0;
        inj_valid = '0; inj_dst = '0; inj_data = '0; dlv_ready = '0;
    endtask

    task automatic put_slot(input int k, input int dst, input int data);
        in_valid[k] = 1'b1;
        in_dst[k*IW +: IW] = IW'(dst);
        in_data[k*DW +: DW] = DW'(data);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        rst = 1'b1;
        tick(); tick(); tick();
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1 out_valid", 32'(out_valid), 0);
        check("R1 dlv_valid", 32'(dlv_valid), 0);
        check("R1 inj_ready", 32'(inj_ready), 0);

        // R6, R7, R9: injection sweep over every class and destination
        for (int c = 0; c < NC; c++) begin
            for (int d = 0; d < N; d++) begin
                int cw;
                int ccw;
                int e;
                cw  = (d - ME + N) % N;
                ccw = (ME - d + N) % N;
                e   = (ccw < cw) ? 1 : 0;
                in_empty_next = '1;
                tick();
                inj_valid[c] = 1'b1;
                inj_dst[c*IW +: IW] = IW'(d);
                inj_data[c*DW +: DW] = DW'(16'h100 + c*16 + d);
                #1;
                check("R7 ready when announced empty", 32'(inj_ready[c]), 1);
                tick();
                check("R6/R9 lane select", 32'(out_valid), 32'(1 << (2*c + e)));
                check("R6 dst", 32'(out_dst[(2*c+e)*IW +: IW]), 32'(d));
                check("R6 data", 32'(out_data[(2*c+e)*DW +: DW]), 32'(16'h100 + c*16 + d));
                inj_valid[c] = 1'b0;
            end
        end
        clear_inputs();
        tick(); tick();

        // R7, R8: injection held while chosen lane not announced empty
        in_empty_next = '0;
        tick();
        inj_valid[0] = 1'b1;
        inj_dst[0 +: IW] = IW'(3);          // one hop clockwise
        inj_data[0 +: DW] = 16'hBEEF;
        put_slot(0, 4, 16'h0C0C);            // transit slot, not announced
        #1;
        check("R7 not ready without hint", 32'(inj_ready[0]), 0);
        in_empty_next[1] = 1'b1;             // only the unused direction announced
        tick();
        check("R8 transit slot passes", 32'(out_data[0 +: DW]), 32'h0C0C);
        check("R8 transit dst", 32'(out_dst[0 +: IW]), 4);
        in_valid = '0;
        #1;
        check("R7 other direction hint ignored", 32'(inj_ready[0]), 0);
        in_empty_next[0] = 1'b1;
        tick();
        check("R7 nothing injected while waiting", 32'(out_valid), 0);
        check("R7 ready after hint", 32'(inj_ready[0]), 1);
        tick();
        check("R7 held message lands", 32'(out_data[0 +: DW]), 32'hBEEF);
        check("R7 lands clockwise", 32'(out_valid), 1);
        clear_inputs();
        tick();

        // R2: pass-through one hop per clock
        put_slot(3, 5, 16'h00AB);
        #1;
        check("R2 early empty low", 32'(out_empty_next[3]), 0);
        tick();
        check("R2 out_valid", 32'(out_valid), 32'(1 << 3));
        check("R2 dst", 32'(out_dst[3*IW +: IW]), 5);
        check("R2 data", 32'(out_data[3*DW +: DW]), 32'h00AB);
        clear_inputs();

        // R3: delivery with ready
        put_slot(4, ME, 16'h5A5A);
        dlv_ready[2] = 1'b1;
        #1;
        check("R3 dlv_valid", 32'(dlv_valid), 32'(1 << 2));
        check("R3 dlv_data", 32'(dlv_data[2*DW +: DW]), 32'h5A5A);
        check("R3 early empty high", 32'(out_empty_next[4]), 1);
        tick();
        check("R3 slot emptied", 32'(out_valid), 0);
        clear_inputs();

        // R4: delivery not ready
        put_slot(4, ME, 16'h1234);
        #1;
        check("R4 offered", 32'(dlv_valid[2]), 1);
        tick();
        check("R4 stays on ring", 32'(out_valid), 32'(1 << 4));
        check("R4 dst kept", 32'(out_dst[4*IW +: IW]), ME);
        check("R4 data kept", 32'(out_data[4*DW +: DW]), 32'h1234);
        clear_inputs();

        // R5: both lanes of one class hit
        put_slot(6, ME, 16'h0011);
        put_slot(7, ME, 16'h0022);
        dlv_ready[3] = 1'b1;
        #1;
        check("R5 clockwise delivered", 32'(dlv_data[3*DW +: DW]), 32'h0011);
        tick();
        check("R5 ccw continues", 32'(out_valid), 32'(1 << 7));
        check("R5 ccw data", 32'(out_data[7*DW +: DW]), 32'h0022);
        clear_inputs();
        tick();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule